// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This block adds or subtracts two signed-magnitude numbers of `W` bits. Each operand carries a sign bit on top and an unsigned magnitude of `W-1` bits below it. A single control bit picks addition or subtraction. Subtraction is handled by flipping the sign of the second operand and then doing a signed addition.

Internally there is exactly one unsigned magnitude adder. When the effective signs agree, the two magnitudes are summed and the common sign is kept. A carry out of the magnitude field flags overflow. When the effective signs differ, the first magnitude is complemented on its way into the adder. A comparator then selects between two options: a carry-in of one, or a complement of the adder output. Either way the result is the larger magnitude minus the smaller one, and it carries the sign of the larger operand.

The result and the overflow flag are registered, and they appear one cycle after an input strobe together with an output strobe. A zero result is always given a positive sign.

Top module: `sm_addsub`

## Requirements
- R1: Bit `W-1` of every operand and of the result is the sign (1 = negative), and bits `W-2:0` are the magnitude. With W=5, `5'b01011` is +11 and `5'b10110` is -6.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high during the following cycle. Otherwise `out_valid` is low during the following cycle.
- R3: When the effective signs agree, the result magnitude is the low `W-1` bits of the sum of the magnitudes. The result sign is the shared sign. `overflow` is 1 exactly when that sum exceeds 2^(W-1)-1.
- R4: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller one. The result sign is the sign of the operand with the larger magnitude, and `overflow` is 0.
- R5: With `op_sub` = 1 the block computes a - b, which is the same as adding a copy of b with its sign bit inverted. With `op_sub` = 0 it computes a + b.
- R6: Both zero encodings (+0 = all zeros, -0 = only the sign bit set) are accepted on either operand, and both act as the value zero.
- R7: A result whose magnitude is zero always has sign 0. The output never shows -0, including after a wrapping overflow.
- R8: A synchronous active-high `rst` clears `out_valid`, `result` and `overflow` at the next rising edge, and it takes priority over `in_valid`.
- R9: While `in_valid` stays low, `result` and `overflow` keep the values of the last accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op_sub are sampled when high |
| op_sub | input | 1 | 0 = add, 1 = subtract (a - b) |
| a | input | W | First operand, signed-magnitude |
| b | input | W | Second operand, signed-magnitude |
| out_valid | output | 1 | High for one cycle per accepted operation |
| result | output | W | Signed-magnitude result |
| overflow | output | 1 | Magnitude sum did not fit on the same-sign path |

## Verification
A fault in the complement controls or in the comparator produces a wrong magnitude or a wrong sign on the very next `out_valid`. This shows up most clearly when the two magnitudes differ by one or are equal. A wrong path decision shows up as a false `overflow` on operands with opposite signs, or as a missing one on large operands with the same sign, again one cycle after the strobe. Sweeping every operand pair in both modes exposes any such error within a single pass. A stale output register shows up as a `result` that changes while the bench is idle.

// File: rtl/sm_pkg.sv
package sm_pkg;

    typedef enum logic {
        PATH_SAME = 1'b0,
        PATH_DIFF = 1'b1
    } path_e;

    typedef struct packed {
        path_e path;
        logic  comp_x;
        logic  cin;
        logic  comp_s;
        logic  pick_b_sign;
    } ctl_t;

    function automatic logic eff_sign_b(input logic sign_b, input logic sub);
        return sign_b ^ sub;
    endfunction

    // a_lt_b: magnitude of a is strictly smaller than magnitude of b
    function automatic ctl_t plan_ctl(input logic sa, input logic sb_eff,
                                      input logic a_lt_b);
        ctl_t c;
        c.path        = (sa == sb_eff) ? PATH_SAME : PATH_DIFF;
        c.comp_x      = (c.path == PATH_DIFF);
        c.cin         = (c.path == PATH_DIFF) && a_lt_b;
        c.comp_s      = (c.path == PATH_DIFF) && !a_lt_b;
        c.pick_b_sign = (c.path == PATH_DIFF) && a_lt_b;
        return c;
    endfunction

endpackage

// File: rtl/sm_mag_cmp.sv
module sm_mag_cmp #(
    parameter int M = 4
) (
    input  logic [M-1:0] x,
    input  logic [M-1:0] y,
    output logic         lt
);
    always_comb lt = (x < y);
endmodule

// File: rtl/sm_mag_adder.sv
module sm_mag_adder #(
    parameter int M = 4
) (
    input  logic [M-1:0] x,
    input  logic [M-1:0] y,
    input  logic         comp_x,
    input  logic         cin,
    input  logic         comp_s,
    output logic [M-1:0] sum,
    output logic         cout
);
    logic [M-1:0] x_sel;
    logic [M:0]   raw;

    always_comb begin
        x_sel = comp_x ? ~x : x;
        raw   = {1'b0, x_sel} + {1'b0, y} + {{M{1'b0}}, cin};
        cout  = raw[M];
        sum   = comp_s ? ~raw[M-1:0] : raw[M-1:0];
    end
endmodule

// File: rtl/sm_out_reg.sv
module sm_out_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d_result,
    input  logic         d_ovf,
    output logic         q_valid,
    output logic [W-1:0] q_result,
    output logic         q_ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid  <= 1'b0;
            q_result <= '0;
            q_ovf    <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q_result <= d_result;
                q_ovf    <= d_ovf;
            end
        end
    end

    // R2: strobe follows the load one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        load |=> q_valid);
    a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !load |=> !q_valid);
    // R9: output register holds while idle
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(q_result) && $stable(q_ovf)));
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
    import sm_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         op_sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         overflow
);
    localparam int M = W - 1;

    logic         sa, sb_eff, a_lt_b, cout, zero_mag, res_sign, ovf_d;
    logic [M-1:0] ma, mb, mag;
    ctl_t         ctl;
    logic [W-1:0] res_d;

    always_comb begin
        sa     = a[W-1];
        sb_eff = eff_sign_b(b[W-1], op_sub);
        ma     = a[M-1:0];
        mb     = b[M-1:0];
    end

    sm_mag_cmp #(.M(M)) u_cmp (
        .x  (ma),
        .y  (mb),
        .lt (a_lt_b)
    );

    always_comb ctl = plan_ctl(sa, sb_eff, a_lt_b);

    sm_mag_adder #(.M(M)) u_add (
        .x      (ma),
        .y      (mb),
        .comp_x (ctl.comp_x),
        .cin    (ctl.cin),
        .comp_s (ctl.comp_s),
        .sum    (mag),
        .cout   (cout)
    );

    always_comb begin
        zero_mag = (mag == '0);
        res_sign = ctl.pick_b_sign ? sb_eff : sa;
        res_d    = {res_sign & ~zero_mag, mag};
        ovf_d    = (ctl.path == PATH_SAME) & cout;
    end

    sm_out_reg #(.W(W)) u_oreg (
        .clk      (clk),
        .rst      (rst),
        .load     (in_valid),
        .d_result (res_d),
        .d_ovf    (ovf_d),
        .q_valid  (out_valid),
        .q_result (result),
        .q_ovf    (overflow)
    );

    // R4: operands with opposite effective signs never report overflow
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (a[W-1] != (b[W-1] ^ op_sub))) |=> !overflow);
    // R7: negative zero never appears on the output
    a_r7_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (result != {1'b1, {M{1'b0}}}));
    // R4: on the differing path the magnitude never exceeds the larger input
    a_r4_mag_bound: assert property (@(posedge clk) disable iff (rst)
        (ctl.path == PATH_DIFF) |-> (mag <= (a_lt_b ? mb : ma)));
    // R8: reset leaves an empty output
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !overflow));
endmodule

// File: tb/sm_addsub_bench.sv
module sm_addsub_bench;
    localparam int W    = 5;
    localparam int M    = W - 1;
    localparam int MAXM = (1 << M) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic         out_valid, overflow;
    logic [W-1:0] result;

    always #2.5 clk = ~clk;

    sm_addsub #(.W(W)) u_sm_addsub (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
        .a(a), .b(b), .out_valid(out_valid), .result(result), .overflow(overflow)
    );

    typedef struct {
        logic [W-1:0] res;
        logic         ovf;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    function automatic exp_t model(bit sub, logic [W-1:0] xa, logic [W-1:0] xb,
                                   string tag);
        exp_t e;
        int va, vb, x, mg, bits;
        va = xa[W-1] ? -int'(xa[M-1:0]) : int'(xa[M-1:0]);
        vb = xb[W-1] ? -int'(xb[M-1:0]) : int'(xb[M-1:0]);
        if (sub) vb = -vb;
        x    = va + vb;
        mg   = (x < 0) ? -x : x;
        bits = mg % (1 << M);
        e.ovf = (mg > MAXM);
        e.res = {((x < 0) && (bits != 0)), bits[M-1:0]};
        e.tag = tag;
        return e;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] expv,
                         logic act_o, logic exp_o);
        n_checks++;
        if (act !== expv || act_o !== exp_o) begin
            n_fail++;
            $display("FAIL %s: result=%b ovf=%b expected result=%b ovf=%b",
                     tag, act, act_o, expv, exp_o);
        end
    endtask

    task automatic apply(bit sub, logic [W-1:0] xa, logic [W-1:0] xb, string tag);
        @(negedge clk);
        in_valid = 1'b1; op_sub = sub; a = xa; b = xb;
        q.push_back(model(sub, xa, xb, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: outputs only move at posedge, sampled at negedge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R2: out_valid=1 expected out_valid=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, result, e.res, overflow, e.ovf);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R2: watchdog expired, actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held_r;
        logic         held_o;
        repeat (3) @(negedge clk);
        check("R8", result, '0, overflow, 1'b0);
        check("R8", {4'b0, out_valid}, '0, 1'b0, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R1: field layout, +11 + (-6) = +5
        apply(0, 5'b01011, 5'b10110, "R1");
        // R4: -11 + 6 = -5, larger magnitude supplies sign
        apply(0, 5'b11011, 5'b00110, "R4");
        // R4: magnitudes differ by one
        apply(0, 5'b00111, 5'b11000, "R4");
        // R3: 15 + 15 overflows, wraps to 14
        apply(0, 5'b01111, 5'b01111, "R3");
        // R7: -8 + -8 wraps to magnitude 0, sign forced positive
        apply(0, 5'b11000, 5'b11000, "R7");
        // R7: x - x gives +0
        apply(1, 5'b10101, 5'b10101, "R7");
        // R6: -0 + -0 and -0 - +0
        apply(0, 5'b10000, 5'b10000, "R6");
        apply(1, 5'b10000, 5'b00000, "R6");
        apply(0, 5'b10000, 5'b00011, "R6");
        // R5: 3 - 9 = -6, -4 - (-9) = +5
        apply(1, 5'b00011, 5'b01001, "R5");
        apply(1, 5'b10100, 5'b11001, "R5");
        idle(3);

        // R9: idle outputs hold
        held_r = result; held_o = overflow;
        idle(4);
        check("R9", result, held_r, overflow, held_o);
        check("R2", {4'b0, out_valid}, '0, 1'b0, 1'b0);

        // exhaustive sweep, back-to-back
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < (1 << W); i++)
                for (int j = 0; j < (1 << W); j++) begin
                    logic [W-1:0] xa, xb;
                    xa = W'(i); xb = W'(j);
                    if (xa[W-1] == (xb[W-1] ^ s[0]))
                        apply(s[0], xa, xb, s[0] ? "R5_R3" : "R3");
                    else
                        apply(s[0], xa, xb, s[0] ? "R5_R4" : "R4");
                end
        idle(3);

        // R8: reset mid-run clears outputs, wins over in_valid
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; a = 5'b01111; b = 5'b01111;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", result, '0, overflow, 1'b0);
        check("R8", {4'b0, out_valid}, '0, 1'b0, 1'b0);
        rst = 1'b0;
        idle(2);

        if (q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R2: %0d results missing expected 0", q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule